// File: doc/BRIEF.md
# Vertical Sync Interval Detector

This block finds the vertical blanking interval in a sampled composite sync stream and drives an active-low vertical sync pulse. The sync input is active low and asynchronous to the system clock. A saturating up/down integrator measures how long sync stays low. Broad vertical pulses push the integrator over a threshold and set an internal vertical flag. Normal line sync and equalizing pulses do not.

The output does not follow the flag directly. It is re-timed by rising edges of sync, so the pulse starts on the serration that follows the first broad pulse. It ends on the first rising edge seen after the flag has dropped. With standard video timing this gives a pulse of fixed width. Some sources send a vertical interval with no serrations. For these, a fallback timer starts the pulse after a set time of unbroken low sync while the flag is up. The end of the pulse follows the same edge rule. All time constants are parameters counted in system clock cycles.

Top module: `vsync_detector`

## Requirements
- R1: While the active-low reset is asserted, the vertical output is high (inactive), and the integrator, flag, fallback timer and output state are cleared. Reset acts immediately, even in the middle of a pulse.
- R2: The integrator counts up by one on each cycle the synchronized sync is low and down by one on each cycle it is high. It saturates at 0 and at INTEG_MAX. The vertical flag is set while the count is at least INTEG_THRESH.
- R3: Normal line sync pulses and equalizing pulses, whose low time stays below INTEG_THRESH, never make the output go active.
- R4: When a sync rising edge is detected while the flag is set and the output is inactive, the output goes low. This happens exactly SYNC_STAGES+1 clock cycles after the input rises.
- R5: While the output is active, sync rising edges detected with the flag set leave it active, so one vertical interval gives exactly one output pulse.
- R6: The active output is released on the first sync rising edge detected with the flag clear, SYNC_STAGES+1 cycles after that input edge. With serrated timing, the width equals the time from the rise after the first broad pulse to the rise that releases it.
- R7: When the output is inactive and sync stays low with the flag set for FALLBACK_CYCLES consecutive cycles, the output goes active. Starting from an empty integrator, this is SYNC_STAGES+INTEG_THRESH+FALLBACK_CYCLES cycles after the input falls.
- R8: A pulse started by the fallback timer ends by the same rule as R6. Because the integrator saturates, the flag drops within INTEG_MAX-INTEG_THRESH+1 high cycles of the long low.
- R9: An isolated low glitch shorter than INTEG_THRESH cycles inside a line does not activate the output.
- R10: The sync input passes through SYNC_STAGES flops. A rising edge is a synchronized high sample whose previous sample was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| csync_n_i | input | 1 | Sampled composite sync, active low, asynchronous |
| vsync_n_o | output | 1 | Vertical sync pulse, active low |

## Verification
The assertions assume that every sync level lasts longer than the synchronizer depth. Otherwise edges vanish, and a start or release would appear without a visible cause. They also assume that INTEG_THRESH lies between 1 and INTEG_MAX. The stimulus holds each sync level for at least seven clock cycles. It uses scaled line timing (200-cycle lines, 85-cycle broad pulses, 7-cycle equalizing pulses) and a parameter set with the threshold well inside the integrator range. This keeps every start and release decision clear of the flag crossing by tens of cycles.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  typedef enum logic {
    VS_IDLE   = 1'b0,
    VS_ACTIVE = 1'b1
  } vs_state_t;
endpackage

// File: rtl/vsd_sync_edge.sv
// Input synchronizer with rising-edge detection on the synchronized level.
module vsd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n_i,
  output logic low_o,
  output logic rise_o
);
  // Index STAGES holds the previous synchronized sample.
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d[0] = async_n_i;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_comb begin
      chain_d[g] = chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign low_o  = ~chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/vsd_integrator.sv
// Saturating up/down counter of sync-low time with a threshold flag.
module vsd_integrator #(
  parameter int MAX    = 1600,
  parameter int THRESH = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_i,
  output logic flag_o
);
  localparam int W = $clog2(MAX + 1);
  localparam logic [W-1:0] MAX_V = W'(MAX);
  localparam logic [W-1:0] THR_V = W'(THRESH);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (low_i) begin
      if (cnt_q != MAX_V) begin
        cnt_d  = cnt_q + W'(1);
        cnt_en = 1'b1;
      end
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign flag_o = (cnt_q >= THR_V);

  // R2: count never exceeds its ceiling
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_V);

  // R2: count moves by at most one per cycle
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1) ||
              cnt_q == $past(cnt_q) - W'(1)));

  // R2: empty integrator with high sync stays empty (no wrap below zero)
  assert_cnt_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/vsd_fallback.sv
// Counts unbroken low sync with the flag up; fires when no serration came.
module vsd_fallback #(
  parameter int CYCLES = 3250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic fire_o
);
  localparam int W = $clog2(CYCLES);
  localparam logic [W-1:0] LAST_V = W'(CYCLES - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = arm_i | (cnt_q != '0);
    if (!arm_i)              cnt_d = '0;
    else if (cnt_q == LAST_V) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign fire_o = arm_i && (cnt_q == LAST_V);

  // R7: timer stays inside its window
  assert_fb_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_V);

  // R7: a broken arm condition restarts the timer
  assert_fb_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> cnt_q == '0);
endmodule

// File: rtl/vsd_out_ctrl.sv
// Output state: start on flagged edge or fallback, release on unflagged edge.
module vsd_out_ctrl
  import vsd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  input  logic rise_i,
  input  logic fire_i,
  output logic idle_o,
  output logic vsync_n_o
);
  vs_state_t state_q, state_d;
  logic      vsync_n_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      VS_IDLE:   if ((flag_i && rise_i) || fire_i) state_d = VS_ACTIVE;
      VS_ACTIVE: if (rise_i && !flag_i)            state_d = VS_IDLE;
      default:   state_d = VS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= VS_IDLE;
      vsync_n_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      vsync_n_q <= (state_d == VS_IDLE);
    end
  end

  assign idle_o    = (state_q == VS_IDLE);
  assign vsync_n_o = vsync_n_q;

  // R4, R7: output only starts while the integrator flag is up
  assert_start_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n_q) |-> $past(flag_i));

  // R6: release only on a detected edge with the flag down
  assert_release_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n_q) |-> $past(rise_i && !flag_i));

  // R5: flagged edges never end an active pulse
  assert_hold_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync_n_q && rise_i && flag_i) |=> !vsync_n_q);
endmodule

// File: rtl/vsync_detector.sv
module vsync_detector #(
  parameter int SYNC_STAGES     = 2,
  parameter int INTEG_MAX       = 1600,
  parameter int INTEG_THRESH    = 1000,
  parameter int FALLBACK_CYCLES = 3250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n_i,
  output logic vsync_n_o
);
  logic sync_low;
  logic sync_rise;
  logic vflag;
  logic fb_fire;
  logic out_idle;
  logic fb_arm;

  vsd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_n_i(csync_n_i),
    .low_o    (sync_low),
    .rise_o   (sync_rise)
  );

  vsd_integrator #(.MAX(INTEG_MAX), .THRESH(INTEG_THRESH)) u_integ (
    .clk   (clk),
    .rst_n (rst_n),
    .low_i (sync_low),
    .flag_o(vflag)
  );

  assign fb_arm = vflag & sync_low & out_idle;

  vsd_fallback #(.CYCLES(FALLBACK_CYCLES)) u_fallback (
    .clk   (clk),
    .rst_n (rst_n),
    .arm_i (fb_arm),
    .fire_o(fb_fire)
  );

  vsd_out_ctrl u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_i   (vflag),
    .rise_i   (sync_rise),
    .fire_i   (fb_fire),
    .idle_o   (out_idle),
    .vsync_n_o(vsync_n_o)
  );
endmodule

// File: tb/vsync_detector_tb_top.sv
`timescale 1ns/1ps
module vsync_detector_tb_top;
  localparam int STG = 2;
  localparam int MAXC = 100;
  localparam int THR = 60;
  localparam int FB = 150;
  localparam int LAT = STG + 1;

  logic clk;
  logic rst_n;
  logic csync_n;
  logic vsync_n;

  int cyc;
  int checks;
  int errors;
  int fall_cnt, rise_cnt, fall_cyc, rise_cyc;
  logic vs_prev;
  bit done;

  vsync_detector #(
    .SYNC_STAGES(STG), .INTEG_MAX(MAXC), .INTEG_THRESH(THR), .FALLBACK_CYCLES(FB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .csync_n_i(csync_n), .vsync_n_o(vsync_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    vs_prev = 1'b1; fall_cnt = 0; rise_cnt = 0; fall_cyc = 0; rise_cyc = 0;
  end
  always @(negedge clk) begin
    if (vs_prev === 1'b1 && vsync_n === 1'b0) begin fall_cnt++; fall_cyc = cyc; end
    if (vs_prev === 1'b0 && vsync_n === 1'b1) begin rise_cnt++; rise_cyc = cyc; end
    vs_prev = vsync_n;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic seg(input int lo, input int hi, output int t_low, output int t_rise);
    @(negedge clk); csync_n = 1'b0; t_low = cyc;
    repeat (lo - 1) @(negedge clk);
    @(negedge clk); csync_n = 1'b1; t_rise = cyc;
    repeat (hi - 1) @(negedge clk);
  endtask

  task automatic lines(input int n);
    int a, b;
    for (int i = 0; i < n; i++) seg(15, 185, a, b);
  endtask

  task automatic equal_pulses(input int n);
    int a, b;
    for (int i = 0; i < n; i++) seg(7, 93, a, b);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; csync_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 output high in reset", int'(vsync_n), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 output high after reset", int'(vsync_n), 1);
  endtask

  task automatic t_plain_lines;
    int f0 = fall_cnt;
    lines(10);
    equal_pulses(6);
    lines(2);
    check("R3 no pulse from lines/equalizing", fall_cnt - f0, 0);
    check("R3 R2 output idle", int'(vsync_n), 1);
  endtask

  task automatic t_glitch;
    int f0 = fall_cnt;
    int a, b;
    seg(15, 80, a, b);
    seg(THR - 10, 55, a, b);
    lines(3);
    check("R9 short glitch ignored", fall_cnt - f0, 0);
  endtask

  task automatic t_standard(input string tag);
    int f0 = fall_cnt, r0 = rise_cnt;
    int a, b, b1_rise, pe2_rise;
    equal_pulses(6);
    for (int i = 0; i < 6; i++) begin
      seg(85, 15, a, b);
      if (i == 0) b1_rise = b;
    end
    check({tag, " R4 start delay"}, fall_cyc - b1_rise, LAT);
    seg(7, 93, a, b);
    seg(7, 93, a, pe2_rise);
    equal_pulses(4);
    lines(3);
    check({tag, " R5 single pulse falls"}, fall_cnt - f0, 1);
    check({tag, " R5 single pulse rises"}, rise_cnt - r0, 1);
    check({tag, " R6 release delay"}, rise_cyc - pe2_rise, LAT);
    check({tag, " R6 width"}, rise_cyc - fall_cyc, pe2_rise - b1_rise);
  endtask

  task automatic t_fallback;
    int f0 = fall_cnt, r0 = rise_cnt;
    int a, b, t_lo, rel_rise;
    equal_pulses(6);
    seg(600, 93, t_lo, b);
    check("R7 fallback start delay", fall_cyc - t_lo, STG + THR + FB);
    seg(7, 93, a, rel_rise);
    equal_pulses(5);
    lines(3);
    check("R7 one fallback pulse", fall_cnt - f0, 1);
    check("R8 R2 fallback release delay", rise_cyc - rel_rise, LAT);
    check("R8 one release", rise_cnt - r0, 1);
  endtask

  task automatic t_reset_mid;
    int a, b, f0;
    equal_pulses(6);
    for (int i = 0; i < 3; i++) seg(85, 15, a, b);
    check("R1 pulse active before reset", int'(vsync_n), 0);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 reset releases output at once", int'(vsync_n), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    f0 = fall_cnt;
    lines(4);
    check("R1 integrator cleared by reset", fall_cnt - f0, 0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    t_reset();
    t_plain_lines();
    t_glitch();
    t_standard("first field");
    t_standard("second field R10");
    t_fallback();
    t_reset_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule